// File: doc/BRIEF.md
# Hall-Commutated Three-Phase Bridge Sequencer

This block converts three Hall sensor logic levels into the six gate commands of a three-phase half-bridge. A direction input picks one of two mirror-image commutation tables; for each rotor sector one leg is sourced, one is sunk and one floats. Speed regulation arrives as a PWM enable that chops only the upper switch of the sourcing leg. During the off-time the lower switch of that leg conducts, so the freewheel current flows through the switch and not through its body diode.

A stop request overrides commutation. A second input then selects between coasting, with every switch off, and shorting the windings through all three lower switches. A current-limit trip and a stall-protection flag each remove upper-side drive. A combined fault input turns every switch off. Each leg has its own dead-time timer, so the upper and lower switch of a leg are never on together and never take over from each other without a gap. The Hall sensor bias enable follows the run state. The control inputs are polarised so that a pin left open and pulled high gives the safe setting: stop, coast and the first table.

Top module: `hall_bridge_seq`

## Requirements
- R1: With `dir_sel`=1, the Hall bits taken as sensor 1, 2, 3 = `hall_in[0]`, `hall_in[1]`, `hall_in[2]` give the phase 1/2/3 states (H = source, L = sink, Z = float) as follows: 100→L,Z,H; 110→Z,L,H; 010→H,L,Z; 011→H,Z,L; 001→Z,H,L; 101→L,H,Z. Phase n maps to bit n-1 of `hi_gate` and `lo_gate`.
- R2: With `dir_sel`=0, each phase takes the state that R1 gives for the bitwise complement of the Hall bits.
- R3: On a sourcing phase, `pwm_on`=1 turns on the upper gate only and `pwm_on`=0 turns on the lower gate only (synchronous rectification). A sinking phase keeps its lower gate on and a floating phase has both gates off, whatever `pwm_on` is.
- R4: The two gates of a leg are never both 1. A gate turns off at the first clock edge after it is no longer wanted. After any turn-off, neither gate of that leg turns on for DEAD_CYC cycles, and it turns on at the edge that ends this gap. A leg that has been off for longer than the gap applies a new command at the next edge.
- R5: While running, Hall codes 000 and 111 turn all six gates off.
- R6: With `stop_req`=1 and `coast_sel`=1, all six gates are off. With `stop_req`=1 and `coast_sel`=0, all three lower gates are on and all three upper gates are off. Neither case depends on the Hall inputs.
- R7: `ilim_trip`=1 acts like `pwm_on`=0: no upper gate is on, and the sourcing leg rectifies through its lower gate.
- R8: `stall_lock`=1 forces all upper gates off. A sourcing leg then rectifies through its lower gate.
- R9: `fault`=1 turns all six gates off one edge later, in every mode, braking included.
- R10: `hall_bias` is 1 one edge after `stop_req` is sampled low and 0 one edge after it is sampled high.
- R11: During reset all gates and `hall_bias` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_in | input | 3 | Hall comparator levels, bit n = sensor n+1 |
| dir_sel | input | 1 | 1 = first table, 0 = mirrored table |
| stop_req | input | 1 | 1 = stop, 0 = run |
| coast_sel | input | 1 | Stop behaviour: 1 = coast, 0 = short brake |
| pwm_on | input | 1 | PWM phase from the speed loop, 1 = drive |
| ilim_trip | input | 1 | Current-limit trip, removes upper drive |
| stall_lock | input | 1 | Stall protection active, upper gates off |
| fault | input | 1 | Combined thermal/undervoltage fault, all off |
| hi_gate | output | 3 | Upper switch commands, bit n = phase n+1 |
| lo_gate | output | 3 | Lower switch commands, bit n = phase n+1 |
| hall_bias | output | 1 | Hall sensor bias enable |

## Verification
The bench builds the block with DEAD_CYC=3 instead of the default of 4. With this value the whole gap after a PWM edge fits in a few cycles, and the bench can check it edge by edge: the lower gate must stay off for exactly three edges and come on at the fourth. The short gap also lets the table walk settle every sector in both directions quickly. A leg whose timer has long expired can then be shown to respond at the very next edge.

// File: rtl/hall_bridge_seq.sv
module hall_bridge_seq #(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_in,
  input  logic       dir_sel,
  input  logic       stop_req,
  input  logic       coast_sel,
  input  logic       pwm_on,
  input  logic       ilim_trip,
  input  logic       stall_lock,
  input  logic       fault,
  output logic [2:0] hi_gate,
  output logic [2:0] lo_gate,
  output logic       hall_bias
);
  localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] GAP_LAST = CW'(DEAD_CYC - 1);

  typedef enum logic [1:0] {PH_Z, PH_H, PH_L} ph_t;

  logic [2:0] sector;
  logic       drive_up;
  ph_t        ph [3];
  logic [2:0] want_hi, want_lo;

  assign sector   = dir_sel ? {hall_in[0], hall_in[1], hall_in[2]}
                            : ~{hall_in[0], hall_in[1], hall_in[2]};
  assign drive_up = pwm_on & ~ilim_trip & ~stall_lock;

  always_comb begin
    case (sector)
      3'b101:  ph = '{PH_L, PH_H, PH_Z};
      3'b100:  ph = '{PH_L, PH_Z, PH_H};
      3'b110:  ph = '{PH_Z, PH_L, PH_H};
      3'b010:  ph = '{PH_H, PH_L, PH_Z};
      3'b011:  ph = '{PH_H, PH_Z, PH_L};
      3'b001:  ph = '{PH_Z, PH_H, PH_L};
      default: ph = '{PH_Z, PH_Z, PH_Z};
    endcase
  end

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      want_hi[i] = 1'b0;
      want_lo[i] = 1'b0;
      if (!fault) begin
        if (stop_req) begin
          want_lo[i] = ~coast_sel;
        end else begin
          case (ph[i])
            PH_H: begin
              want_hi[i] = drive_up;
              want_lo[i] = ~drive_up;
            end
            PH_L:    want_lo[i] = 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_leg
    logic [CW-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_gate[g] <= 1'b0;
        lo_gate[g] <= 1'b0;
        gap_cnt    <= '0;
      end else if ((hi_gate[g] & ~want_hi[g]) | (lo_gate[g] & ~want_lo[g])) begin
        hi_gate[g] <= 1'b0;
        lo_gate[g] <= 1'b0;
        gap_cnt    <= GAP_LAST;
      end else if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - 1'b1;
      end else begin
        hi_gate[g] <= want_hi[g];
        lo_gate[g] <= want_lo[g];
      end
    end

    logic [CW-1:0] off_age;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       off_age <= GAP_LAST;
      else if (hi_gate[g] | lo_gate[g]) off_age <= '0;
      else if (off_age != GAP_LAST)     off_age <= off_age + 1'b1;
    end

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_gate[g] && lo_gate[g]));

    p_dead_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_gate[g] && !lo_gate[g] && off_age < GAP_LAST)
      |=> (!hi_gate[g] && !lo_gate[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hall_bias <= 1'b0;
    else        hall_bias <= ~stop_req;
  end

  p_bad_hall_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_req && (hall_in == 3'b000 || hall_in == 3'b111))
    |=> (hi_gate == 3'b000 && lo_gate == 3'b000));

  p_coast_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && coast_sel) |=> (hi_gate == 3'b000 && lo_gate == 3'b000));

  p_brake_no_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !coast_sel) |=> (hi_gate == 3'b000));

  p_ilim_upper_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_trip |=> (hi_gate == 3'b000));

  p_stall_upper_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_lock |=> (hi_gate == 3'b000));

  p_fault_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (hi_gate == 3'b000 && lo_gate == 3'b000));

  p_bias_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_req |=> hall_bias);

  p_bias_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !hall_bias);
endmodule

// File: tb/tb_hall_bridge_seq.sv
module tb_hall_bridge_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 3;
  localparam int SETTLE = DEAD + 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall_in = 3'b101;
  logic       dir_sel = 1'b1, stop_req = 1'b0, coast_sel = 1'b1, pwm_on = 1'b1;
  logic       ilim_trip = 1'b0, stall_lock = 1'b0, fault = 1'b0;
  logic [2:0] hi_gate, lo_gate;
  logic       hall_bias;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  hall_bridge_seq #(.DEAD_CYC(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_sel(dir_sel),
    .stop_req(stop_req), .coast_sel(coast_sel), .pwm_on(pwm_on),
    .ilim_trip(ilim_trip), .stall_lock(stall_lock), .fault(fault),
    .hi_gate(hi_gate), .lo_gate(lo_gate), .hall_bias(hall_bias)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {dir, hall[2:0], pwm, hi[2:0], lo[2:0]}; bit n of gates = phase n+1
  localparam logic [10:0] VEC [20] = '{
    11'b1_101_1_010_001, 11'b1_001_1_100_001, 11'b1_011_1_100_010,
    11'b1_010_1_001_010, 11'b1_110_1_001_100, 11'b1_100_1_010_100,
    11'b1_101_0_000_011, 11'b1_001_0_000_101, 11'b1_011_0_000_110,
    11'b1_010_0_000_011, 11'b1_110_0_000_101, 11'b1_100_0_000_110,
    11'b0_010_1_010_001, 11'b0_110_1_100_001, 11'b0_100_1_100_010,
    11'b0_101_1_001_010, 11'b0_001_1_001_100, 11'b0_011_1_010_100,
    11'b0_010_0_000_011, 11'b0_101_0_000_011
  };

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11: run-style inputs during reset must not reach the gates
    settle(3);
    chk("R11 reset", {hall_bias, hi_gate, lo_gate}, 7'b0_000_000);
    rst_n = 1'b1;

    // R1 R2 R3 R5: table walk
    for (int k = 0; k < 20; k++) begin
      dir_sel = VEC[k][10]; hall_in = VEC[k][9:7]; pwm_on = VEC[k][6];
      settle(SETTLE);
      chk(VEC[k][10] ? "R1 R3 fwd" : "R2 R3 rev", {1'b1, hi_gate, lo_gate},
          {1'b1, VEC[k][5:0]});
    end

    // R5: illegal codes in both directions
    dir_sel = 1'b1; hall_in = 3'b000; pwm_on = 1'b1; settle(SETTLE);
    chk("R5 code000", {1'b0, hi_gate, lo_gate}, 7'b0);
    hall_in = 3'b111; settle(SETTLE);
    chk("R5 code111", {1'b0, hi_gate, lo_gate}, 7'b0);
    dir_sel = 1'b0; hall_in = 3'b000; settle(SETTLE);
    chk("R5 code000 rev", {1'b0, hi_gate, lo_gate}, 7'b0);

    // R4: exact dead gap when PWM drops on the sourcing leg
    dir_sel = 1'b1; hall_in = 3'b101; pwm_on = 1'b1; settle(SETTLE);
    pwm_on = 1'b0;
    for (int k = 1; k <= DEAD; k++) begin
      settle(1);
      chk("R4 gap hold", {1'b0, hi_gate, lo_gate}, {1'b0, 3'b000, 3'b001});
    end
    settle(1);
    chk("R4 gap end", {1'b0, hi_gate, lo_gate}, {1'b0, 3'b000, 3'b011});

    // R6 R10: coast stop, immediate off
    pwm_on = 1'b1; settle(SETTLE);
    stop_req = 1'b1; coast_sel = 1'b1;
    settle(1);
    chk("R6 coast", {hall_bias, hi_gate, lo_gate}, 7'b0_000_000);
    hall_in = 3'b010; settle(SETTLE);
    chk("R6 coast hall ignored", {hall_bias, hi_gate, lo_gate}, 7'b0_000_000);

    // R4 R10: expired timers apply at the next edge
    hall_in = 3'b101; stop_req = 1'b0;
    settle(1);
    chk("R4 R10 run start", {hall_bias, hi_gate, lo_gate}, {1'b1, 3'b010, 3'b001});

    // R6: short brake, independent of hall
    settle(SETTLE);
    stop_req = 1'b1; coast_sel = 1'b0; settle(SETTLE);
    chk("R6 brake", {hall_bias, hi_gate, lo_gate}, {1'b0, 3'b000, 3'b111});
    hall_in = 3'b000; settle(SETTLE);
    chk("R6 brake hall ignored", {hall_bias, hi_gate, lo_gate}, {1'b0, 3'b000, 3'b111});

    // R9: fault during brake
    fault = 1'b1; settle(1);
    chk("R9 fault brake", {1'b0, hi_gate, lo_gate}, 7'b0);
    fault = 1'b0; stop_req = 1'b0; coast_sel = 1'b1; hall_in = 3'b011; pwm_on = 1'b1;
    settle(SETTLE);
    chk("R1 resume", {hall_bias, hi_gate, lo_gate}, {1'b1, 3'b100, 3'b010});

    // R7: current trip rectifies
    ilim_trip = 1'b1; settle(1);
    chk("R7 trip upper off", {1'b0, hi_gate, 3'b000}, 7'b0);
    settle(SETTLE);
    chk("R7 trip rectify", {1'b0, hi_gate, lo_gate}, {1'b0, 3'b000, 3'b110});
    ilim_trip = 1'b0; settle(SETTLE);

    // R8: stall protection
    stall_lock = 1'b1; settle(1);
    chk("R8 stall upper off", {1'b0, hi_gate, 3'b000}, 7'b0);
    settle(SETTLE);
    chk("R8 stall rectify", {1'b0, hi_gate, lo_gate}, {1'b0, 3'b000, 3'b110});
    stall_lock = 1'b0; settle(SETTLE);

    // R9: fault in run
    fault = 1'b1; settle(1);
    chk("R9 fault run", {1'b0, hi_gate, lo_gate}, 7'b0);
    fault = 1'b0; settle(SETTLE);
    chk("R3 after fault", {1'b0, hi_gate, lo_gate}, {1'b0, 3'b100, 3'b010});

    // R10: bias drops one edge after stop
    stop_req = 1'b1; settle(1);
    chk("R10 bias off", {6'b0, hall_bias}, 7'b0);

    // R11: reset mid-run
    stop_req = 1'b0; settle(SETTLE);
    rst_n = 1'b0; settle(1);
    chk("R11 reset run", {hall_bias, hi_gate, lo_gate}, 7'b0);
    rst_n = 1'b1; settle(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule